// File: doc/BRIEF.md
# Pipelined SPI ADC Scan Sequencer

The block is an SPI master that sweeps a chosen set of inputs on an external multichannel successive-approximation converter. The converter talks in 16-bit frames, and it returns each conversion two frames after the command that requested it. A one-cycle `start` pulse captures a 16-bit channel-enable mask. The sequencer then sends one conversion command for each enabled channel, lowest index first. It appends two all-zero frames that push the last results out of the converter. Each returned word is paired with the command sent two frames earlier.

Results leave on a valid/ready stream. Each result carries the channel that was commanded, the left-aligned sample, and an error flag. The flag is set when the channel tag echoed by the converter does not match that channel. A one-cycle `scan_done` pulse follows the last accepted result. The serial side runs SPI mode 0, most significant bit first. Chip select goes high after every word. The serial clock comes from a programmable divider.

The controller has five states:
- `S_IDLE` waits for `start`.
- `S_ISSUE` picks the next command and launches a frame.
- `S_XFER` waits for the frame to finish.
- `S_EMIT` presents a realigned result until it is accepted.
- `S_FINISH` pulses `scan_done`.

The transitions are:
- `S_IDLE` goes to `S_ISSUE` on start with a nonzero mask, and to `S_FINISH` on start with a zero mask.
- `S_ISSUE` always goes to `S_XFER`.
- `S_XFER` goes to `S_EMIT` when the finished frame carried a result owed to a real command.
- Otherwise `S_XFER` goes to `S_ISSUE` while frames remain, or to `S_FINISH` when none remain.
- `S_EMIT` goes to `S_ISSUE` or to `S_FINISH` once the result is accepted.
- `S_FINISH` always goes back to `S_IDLE`.

Top module: `adc_scan_seq`

## Requirements
- R1: A `start` pulse seen while idle with a nonzero mask makes `busy` high in the next cycle and begins the first frame.
- R2: A conversion command is the 16-bit word with bit 12 set, bit 11 clear, the channel number in bits 10:7, and every other bit zero. The word equals 0x1000 plus the channel shifted left by 7.
- R3: Commands are issued exactly once per set mask bit, in ascending channel order.
- R4: A scan with N enabled channels uses exactly N+2 frames. The last two frames carry the word 0x0000.
- R5: Every frame holds 16 rising edges of `sclk` while `cs_n` is low, and `cs_n` returns high between frames. `sclk` idles low, `mosi` changes after falling edges, and `miso` is sampled on rising edges, most significant bit first.
- R6: Each high or low phase of `sclk` lasts `clk_div` system cycles. A divider value of 0 behaves as 1.
- R7: The k-th result reports the k-th commanded channel, and its sample is bits 11:0 of the word received in frame k+2. Words received in the first two frames of a scan are never forwarded.
- R8: `res_tag_err` is high exactly when bits 15:12 of the received word differ from the reported channel.
- R9: While `res_valid` is high and `res_ready` is low, the result fields hold steady and the scan does not advance.
- R10: `scan_done` is a single-cycle pulse that comes only after every result has been accepted. `busy` is low in the cycle after it.
- R11: A start with a zero mask raises `scan_done` in the next cycle and produces no chip-select activity.
- R12: A `start` pulse during a scan is ignored, and so is any change of `chan_mask` after the start cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Scan request pulse, honoured only when idle |
| chan_mask | input | 16 | Channel-enable mask, captured on start |
| clk_div | input | 8 | System cycles per `sclk` phase (0 acts as 1) |
| sclk | output | 1 | SPI serial clock, idles low |
| cs_n | output | 1 | SPI chip select, active low, one word per assertion |
| mosi | output | 1 | Serial command data out |
| miso | input | 1 | Serial result data in |
| res_valid | output | 1 | Result available |
| res_ready | input | 1 | Consumer accepts the result |
| res_chan | output | 4 | Channel the result belongs to |
| res_sample | output | 12 | Sample bits taken from the received word |
| res_tag_err | output | 1 | Echoed tag differs from the channel |
| scan_done | output | 1 | One-cycle end-of-scan pulse |
| busy | output | 1 | Scan in progress |

## Verification
Two things can fall on the same cycle. A frame can finish while the previous result is still waiting for `res_ready`. A new `start` can arrive while a scan is running. The bench provokes the first by dropping `res_ready` at random and checking that fields stay frozen and that no extra command reaches the converter model. It provokes the second by pulsing `start` in the middle of a long scan with a different mask. The command log from the converter model must then match the original mask alone, followed by its two zero frames.

// File: rtl/adc_seq_pkg.sv
package adc_seq_pkg;

    localparam int FRAME_BITS = 16;
    localparam int NUM_CH     = 16;
    localparam int CH_BITS    = $clog2(NUM_CH);
    localparam int CONV_BIT   = 12;
    localparam int CH_LSB     = 7;

    typedef enum logic [2:0] {
        S_IDLE,
        S_ISSUE,
        S_XFER,
        S_EMIT,
        S_FINISH
    } seq_state_t;

    // lowest set index of a mask (0 when empty)
    function automatic logic [CH_BITS-1:0] lowest_set(input logic [NUM_CH-1:0] m);
        logic [CH_BITS-1:0] r;
        r = '0;
        for (int i = NUM_CH - 1; i >= 0; i--) begin
            if (m[i]) r = CH_BITS'(i);
        end
        return r;
    endfunction

    // manual conversion command for one channel
    function automatic logic [FRAME_BITS-1:0] conv_cmd(input logic [CH_BITS-1:0] ch);
        logic [FRAME_BITS-1:0] w;
        w = '0;
        w[CONV_BIT] = 1'b1;
        w[CH_LSB +: CH_BITS] = ch;
        return w;
    endfunction

endpackage

// File: rtl/adc_spi_shifter.sv
module adc_spi_shifter #(
    parameter int WORD  = 16,
    parameter int DIV_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             go,
    input  logic [WORD-1:0]  tx_word,
    input  logic [DIV_W-1:0] div,
    input  logic             miso,
    output logic             sclk,
    output logic             cs_n,
    output logic             mosi,
    output logic             done,
    output logic [WORD-1:0]  rx_word,
    output logic             active
);
    localparam int HW = $clog2(2 * WORD);
    localparam logic [HW-1:0] LAST_PHASE = HW'(2 * WORD - 1);

    logic [DIV_W-1:0] half, cnt;
    logic [HW-1:0]    phase;
    logic [WORD-1:0]  tx_sh, rx_sh;

    assign half = (div == '0) ? DIV_W'(1) : div;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            active <= 1'b0;
            sclk   <= 1'b0;
            cnt    <= '0;
            phase  <= '0;
            tx_sh  <= '0;
            rx_sh  <= '0;
            done   <= 1'b0;
        end else begin
            done <= 1'b0;
            if (!active) begin
                if (go) begin
                    active <= 1'b1;
                    tx_sh  <= tx_word;
                    cnt    <= '0;
                    phase  <= '0;
                    sclk   <= 1'b0;
                end
            end else if (cnt == half - DIV_W'(1)) begin
                cnt   <= '0;
                phase <= phase + HW'(1);
                if (!sclk) begin
                    sclk  <= 1'b1;
                    rx_sh <= {rx_sh[WORD-2:0], miso};
                end else begin
                    sclk  <= 1'b0;
                    tx_sh <= {tx_sh[WORD-2:0], 1'b0};
                    if (phase == LAST_PHASE) begin
                        active <= 1'b0;
                        done   <= 1'b1;
                    end
                end
            end else begin
                cnt <= cnt + DIV_W'(1);
            end
        end
    end

    assign cs_n    = ~active;
    assign mosi    = tx_sh[WORD-1];
    assign rx_word = rx_sh;

    // R5
    sclk_idle_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cs_n |-> !sclk);

    // R5
    go_only_when_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        go |-> !active);

endmodule

// File: rtl/adc_scan_ctrl.sv
module adc_scan_ctrl
    import adc_seq_pkg::*;
#(
    parameter int SAMPLE_BITS = 12
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   start,
    input  logic [NUM_CH-1:0]      chan_mask,
    input  logic                   xfer_done,
    input  logic [FRAME_BITS-1:0]  rx_word,
    input  logic                   res_ready,
    output logic                   go,
    output logic [FRAME_BITS-1:0]  tx_word,
    output logic                   res_valid,
    output logic [CH_BITS-1:0]     res_chan,
    output logic [SAMPLE_BITS-1:0] res_sample,
    output logic                   res_tag_err,
    output logic                   scan_done,
    output logic                   busy
);
    localparam int TAG_LSB = FRAME_BITS - CH_BITS;
    localparam int SMP_MSB = TAG_LSB - 1;

    seq_state_t state, nxt;

    logic [NUM_CH-1:0]  pend;
    logic [CH_BITS-1:0] cur_ch, exp0, exp1, pick;
    logic               cur_real, v0, v1, more, have, cont;

    assign pick = lowest_set(pend);
    assign have = |pend;
    assign cont = have || cur_real || v0;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= S_IDLE;
        else        state <= nxt;
    end

    always_comb begin
        nxt = state;
        unique case (state)
            S_IDLE:   if (start) nxt = (chan_mask == '0) ? S_FINISH : S_ISSUE;
            S_ISSUE:  nxt = S_XFER;
            S_XFER:   if (xfer_done) begin
                          if (v1)        nxt = S_EMIT;
                          else if (cont) nxt = S_ISSUE;
                          else           nxt = S_FINISH;
                      end
            S_EMIT:   if (res_ready) nxt = more ? S_ISSUE : S_FINISH;
            S_FINISH: nxt = S_IDLE;
            default:  nxt = S_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pend        <= '0;
            cur_ch      <= '0;
            cur_real    <= 1'b0;
            exp0        <= '0;
            exp1        <= '0;
            v0          <= 1'b0;
            v1          <= 1'b0;
            more        <= 1'b0;
            res_chan    <= '0;
            res_sample  <= '0;
            res_tag_err <= 1'b0;
        end else begin
            unique case (state)
                S_IDLE: if (start && chan_mask != '0) begin
                    pend <= chan_mask;
                    v0   <= 1'b0;
                    v1   <= 1'b0;
                end
                S_ISSUE: begin
                    cur_real <= have;
                    cur_ch   <= have ? pick : '0;
                    if (have) pend[pick] <= 1'b0;
                end
                S_XFER: if (xfer_done) begin
                    exp1 <= exp0;
                    v1   <= v0;
                    exp0 <= cur_ch;
                    v0   <= cur_real;
                    more <= cont;
                    if (v1) begin
                        res_chan    <= exp1;
                        res_sample  <= rx_word[SMP_MSB -: SAMPLE_BITS];
                        res_tag_err <= (rx_word[FRAME_BITS-1:TAG_LSB] != exp1);
                    end
                end
                S_EMIT, S_FINISH: ;
                default: ;
            endcase
        end
    end

    always_comb begin
        go        = (state == S_ISSUE);
        tx_word   = (state == S_ISSUE && have) ? conv_cmd(pick) : '0;
        res_valid = (state == S_EMIT);
        scan_done = (state == S_FINISH);
        busy      = (state != S_IDLE);
    end

    // R9
    hold_while_stalled_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (res_valid && !res_ready) |=> (res_valid && $stable(res_chan)
                                       && $stable(res_sample) && $stable(res_tag_err)));

    // R7
    result_after_frame_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(res_valid) |-> $past(xfer_done));

    // R10
    done_after_drain_chk: assert property (@(posedge clk) disable iff (!rst_n)
        scan_done |-> (!v0 && !v1 && pend == '0));

endmodule

// File: rtl/adc_scan_seq.sv
module adc_scan_seq
    import adc_seq_pkg::*;
#(
    parameter int DIV_W       = 8,
    parameter int SAMPLE_BITS = 12
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   start,
    input  logic [NUM_CH-1:0]      chan_mask,
    input  logic [DIV_W-1:0]       clk_div,
    output logic                   sclk,
    output logic                   cs_n,
    output logic                   mosi,
    input  logic                   miso,
    output logic                   res_valid,
    input  logic                   res_ready,
    output logic [CH_BITS-1:0]     res_chan,
    output logic [SAMPLE_BITS-1:0] res_sample,
    output logic                   res_tag_err,
    output logic                   scan_done,
    output logic                   busy
);
    logic                  go, xfer_done, xfer_active;
    logic [FRAME_BITS-1:0] tx_word, rx_word;

    adc_scan_ctrl #(.SAMPLE_BITS(SAMPLE_BITS)) u_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .start      (start),
        .chan_mask  (chan_mask),
        .xfer_done  (xfer_done),
        .rx_word    (rx_word),
        .res_ready  (res_ready),
        .go         (go),
        .tx_word    (tx_word),
        .res_valid  (res_valid),
        .res_chan   (res_chan),
        .res_sample (res_sample),
        .res_tag_err(res_tag_err),
        .scan_done  (scan_done),
        .busy       (busy)
    );

    adc_spi_shifter #(.WORD(FRAME_BITS), .DIV_W(DIV_W)) u_spi (
        .clk    (clk),
        .rst_n  (rst_n),
        .go     (go),
        .tx_word(tx_word),
        .div    (clk_div),
        .miso   (miso),
        .sclk   (sclk),
        .cs_n   (cs_n),
        .mosi   (mosi),
        .done   (xfer_done),
        .rx_word(rx_word),
        .active (xfer_active)
    );

    // R11
    zero_mask_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && start && chan_mask == '0) |=> (cs_n && scan_done));

    // R5
    no_frame_when_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> !xfer_active);

endmodule

// File: tb/sim_adc_scan_seq.sv
module sim_adc_scan_seq;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        start;
    logic [15:0] chan_mask;
    logic [7:0]  clk_div;
    logic        res_ready;
    logic        miso = 1'b1;
    logic        sclk, cs_n, mosi, res_valid, res_tag_err, scan_done, busy;
    logic [3:0]  res_chan;
    logic [11:0] res_sample;

    int checks = 0;
    int fails  = 0;
    int cyc_total = 0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    adc_scan_seq u0 (
        .clk(clk), .rst_n(rst_n), .start(start), .chan_mask(chan_mask),
        .clk_div(clk_div), .sclk(sclk), .cs_n(cs_n), .mosi(mosi), .miso(miso),
        .res_valid(res_valid), .res_ready(res_ready), .res_chan(res_chan),
        .res_sample(res_sample), .res_tag_err(res_tag_err),
        .scan_done(scan_done), .busy(busy)
    );

    // ---------------- converter model ----------------
    logic [15:0] s_tx = 16'hFFFF;
    logic [15:0] s_rx = 16'h0000;
    logic [15:0] r_a = 16'hFFFF;
    logic [15:0] r_b = 16'hFFFF;
    logic [15:0] cmd_log [0:1023];
    int cmd_n = 0;
    int frame_no = 0;
    int frame_bad = 0;
    int s_bits = 0;
    int last_frame = -1;
    int corrupt_cmd = -1;

    function automatic logic [11:0] samp(input int ch, input int idx);
        return 12'((ch * 37 + idx * 113 + 5) & 32'hFFF);
    endfunction

    always @(posedge sclk) begin
        if (!cs_n) begin
            if (last_frame != frame_no) begin
                s_bits = 0;
                last_frame = frame_no;
            end
            s_rx = {s_rx[14:0], mosi};
            s_bits++;
        end
    end

    always @(posedge cs_n or negedge sclk) begin
        if (cs_n === 1'b1 && rst_n === 1'b1) begin
            logic [15:0] resp;
            logic [3:0]  tg;
            if (last_frame != frame_no || s_bits != 16) frame_bad++;
            if (cmd_n < 1024) cmd_log[cmd_n] = s_rx;
            if (s_rx[12]) begin
                tg = s_rx[10:7];
                if (cmd_n == corrupt_cmd) tg = tg ^ 4'h5;
                resp = {tg, samp(int'(s_rx[10:7]), cmd_n)};
            end else begin
                resp = 16'h0ABC;
            end
            cmd_n++;
            frame_no++;
            r_b = r_a;
            r_a = resp;
            s_tx = r_b;
            miso = s_tx[15];
        end else if (cs_n === 1'b0) begin
            s_tx = {s_tx[14:0], 1'b0};
            miso = s_tx[15];
        end
    end

    // ---------------- checking helpers ----------------
    task automatic chk(input string req, input string what, input longint act, input longint expv);
        checks++;
        if (act != expv) begin
            fails++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, expv);
        end
    endtask

    always @(posedge clk) begin
        cyc_total++;
        if (cyc_total > 190000) begin
            $display("FAIL watchdog: actual=%0d expected<190000 cycles", cyc_total);
            $display("  [TB] %0d tests run, %0d failed", checks + 1, fails + 1);
            $finish;
        end
    end

    task automatic run_scan(input logic [15:0] mask, input logic [7:0] div, input int rdy_pct,
                            input int corrupt_k, input int restart_at);
        int n, n_start, fb_start, got, half, run, rmin, rmax;
        int chs [16];
        bit prev_stall, done_seen, cs_seen;
        logic [3:0] pc;
        logic [11:0] ps;
        logic pe, prev_sclk;
        n = 0;
        for (int i = 0; i < 16; i++) if (mask[i]) begin chs[n] = i; n++; end
        n_start = cmd_n;
        fb_start = frame_bad;
        corrupt_cmd = (corrupt_k < 0) ? -1 : n_start + corrupt_k;
        half = (div == 0) ? 1 : int'(div);
        chan_mask = mask;
        clk_div = div;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        chan_mask = 16'($urandom);
        got = 0; run = 0; rmin = 1000000; rmax = 0;
        prev_sclk = 1'b0; prev_stall = 1'b0; done_seen = 1'b0; cs_seen = 1'b0;
        pc = '0; ps = '0; pe = 1'b0;
        if (n > 0) chk("R1", "busy after start", busy, 1);
        for (int cyc = 0; cyc < 40000 && !done_seen; cyc++) begin
            start = (cyc == restart_at);  // R12 stimulus
            res_ready = (int'($urandom % 100) < rdy_pct);
            if (prev_stall) begin
                chk("R9", "stall valid", res_valid, 1);
                chk("R9", "stall chan", res_chan, pc);
                chk("R9", "stall sample", res_sample, ps);
                chk("R9", "stall err", res_tag_err, pe);
            end
            if (!cs_n) begin
                cs_seen = 1'b1;
                if (sclk != prev_sclk) begin
                    if (run > 0) begin
                        if (run < rmin) rmin = run;
                        if (run > rmax) rmax = run;
                    end
                    run = 1;
                end else run++;
            end else run = 0;
            prev_sclk = sclk;
            if (res_valid && res_ready) begin
                if (got < n) begin
                    chk("R7", "result chan", res_chan, chs[got]);
                    chk("R7", "result sample", res_sample, samp(chs[got], n_start + got));
                    chk("R8", "tag err", res_tag_err, (got == corrupt_k) ? 1 : 0);
                end else chk("R7", "extra result", got, n);
                got++;
            end
            prev_stall = res_valid && !res_ready;
            pc = res_chan; ps = res_sample; pe = res_tag_err;
            if (scan_done) begin
                done_seen = 1'b1;
                chk("R10", "results before done", got, n);
                if (n == 0) begin
                    chk("R11", "done cycle", cyc, 0);
                    chk("R11", "no chip select", cs_seen, 0);
                end
            end
            if (!done_seen) @(negedge clk);
        end
        start = 1'b0;
        chk("R10", "done seen", done_seen, 1);
        @(negedge clk);
        chk("R10", "done one cycle", scan_done, 0);
        chk("R10", "idle after done", busy, 0);
        chk("R4", "frame count", cmd_n - n_start, (n == 0) ? 0 : n + 2);
        chk("R5", "bad frames", frame_bad - fb_start, 0);
        if (n > 0 && cmd_n - n_start == n + 2) begin
            for (int k = 0; k < n; k++)
                chk("R2", "command word", cmd_log[n_start + k], 16'h1000 | (16'(chs[k]) << 7));
            chk("R4", "trailing zero 1", cmd_log[n_start + n], 0);
            chk("R4", "trailing zero 2", cmd_log[n_start + n + 1], 0);
            chk("R6", "min half period", rmin, half);
            chk("R6", "max half period", rmax, half);
        end
        if (restart_at >= 0) chk("R12", "restart ignored frames", cmd_n - n_start, n + 2);
        if (n > 0) chk("R3", "results count", got, n);
    endtask

    initial begin
        void'($urandom(32'd20240905));
        rst_n = 1'b0; start = 1'b0; chan_mask = '0; clk_div = 8'd1; res_ready = 1'b1;
        repeat (3) @(negedge clk);
        chk("R5", "reset cs_n", cs_n, 1);
        chk("R5", "reset sclk", sclk, 0);
        chk("R10", "reset busy", busy, 0);
        chk("R9", "reset valid", res_valid, 0);
        chk("R10", "reset done", scan_done, 0);
        rst_n = 1'b1;
        @(negedge clk);
        // directed corners
        run_scan(16'h0001, 8'd1, 100, -1, -1);   // R4 single channel
        run_scan(16'hFFFF, 8'd0, 100, -1, -1);   // R6 divider zero, R3 all channels
        run_scan(16'h8000, 8'd3, 100, -1, -1);   // top channel
        run_scan(16'h0000, 8'd2, 100, -1, -1);   // R11
        run_scan(16'h0A50, 8'd2, 100, 1, -1);    // R8 tag corruption
        run_scan(16'hF0F1, 8'd2, 40, -1, 40);    // R12 restart mid-scan, R9 stalls
        run_scan(16'h1234, 8'd1, 20, 2, -1);     // R9 heavy back-pressure
        // random mix
        for (int t = 0; t < 20; t++) begin
            logic [15:0] m;
            int k;
            m = 16'($urandom);
            k = ($urandom % 3 == 0) ? int'($urandom % 4) : -1;
            if (k >= $countones(m)) k = -1;
            run_scan(m, 8'($urandom % 4), 30 + int'($urandom % 71), k, -1);
        end
        $display("  [TB] %0d tests run, %0d failed", checks, fails);
        $finish;
    end

endmodule